// File: doc/BRIEF.md
# Parallel Sampling Converter Read Controller

This block sits on the host side of a 16-bit sampling analog-to-digital converter that has a parallel output bus and separate pins for select, conversion start, read enable and a ready flag. The converter's output drivers stay three-stated until the host reads them. A single request pulse makes the controller do four things in order. It selects the converter, then pulses the active-low start strobe. It waits for the ready flag to come back high and then drives read enable low long enough for the bus to settle. Finally it latches the two's-complement word and presents it with a one-cycle valid pulse.

All converter timing is counted in clock cycles set by parameters:
- select-to-start setup
- start strobe low time
- worst-case conversion time plus a timeout margin
- read access time
- bus release time
- rest interval between conversions

If the ready flag never returns, a timeout pulse ends the transaction. A request that arrives before the controller is idle again is dropped and reported with an overrun pulse.

Top module: `adc_par_reader`

## Requirements
- R1: While reset is asserted, sel_n_o, start_n_o and rden_n_o are high, and smp_vld_o, tmo_o and ovr_o are low.
- R2: A request accepted in idle drives sel_n_o low. start_n_o falls exactly SEL_SETUP cycles later, and sel_n_o is still low when it falls.
- R3: start_n_o stays low for exactly START_LOW cycles. It falls once per accepted request.
- R4: rden_n_o falls exactly 3 cycles after rdy_i rises: two synchronizer stages plus an edge detect. It is never low while rdy_i is low or while start_n_o is low.
- R5: The bus is sampled on the last of RD_ACCESS cycles with rden_n_o low. The word appears on smp_o with a one-cycle smp_vld_o pulse, 3+RD_ACCESS cycles after rdy_i rises. smp_o holds that value until the next valid pulse.
- R6: After the read, sel_n_o stays low for RD_RELEASE cycles and then stays high for at least REST_CYC cycles before the next select. The next start falls at least REST_CYC cycles after the previous rise of rdy_i.
- R7: If rdy_i does not rise within CONV_MAX+TMO_MARGIN cycles after start_n_o rises, tmo_o pulses for one cycle at that count. In that case no read happens and no valid pulse is given, and the controller returns to idle through the rest interval.
- R8: A request seen while the controller is not idle gives a one-cycle ovr_o pulse on the next cycle. It starts no conversion.
- R9: The captured word passes unchanged as 16-bit two's complement with bit 15 as the most significant bit. 16'h8000 is the most negative value and 16'h7FFF the most positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Sample request, accepted in idle |
| rdy_i | input | 1 | Converter ready flag, low while converting |
| bus_i | input | DW | Converter parallel data bus |
| start_n_o | output | 1 | Active-low conversion start strobe |
| sel_n_o | output | 1 | Active-low converter select |
| rden_n_o | output | 1 | Active-low read enable |
| smp_vld_o | output | 1 | One-cycle pulse: new sample on smp_o |
| smp_o | output | DW | Last captured sample |
| tmo_o | output | 1 | One-cycle pulse: conversion timeout |
| ovr_o | output | 1 | One-cycle pulse: request rejected |

## Verification
The bench shrinks the counts to SEL_SETUP=2, START_LOW=3, CONV_MAX=80, TMO_MARGIN=8, RD_ACCESS=4, RD_RELEASE=3 and REST_CYC=6. With these values a stuck converter reaches the timeout after 88 cycles, and dozens of full transactions fit in a short run. A converter model in the bench returns a wrong word on the bus until read enable has been low for two cycles, so a read window that is too short shows up as a data mismatch. Conversion lengths range from a single cycle up to close to the timeout limit, and requests are injected during conversion and during the rest interval.

// File: rtl/adc_par_reader.sv
module adc_par_reader #(
  parameter int DW         = 16,
  parameter int SEL_SETUP  = 2,
  parameter int START_LOW  = 6,
  parameter int CONV_MAX   = 350,
  parameter int TMO_MARGIN = 32,
  parameter int RD_ACCESS  = 10,
  parameter int RD_RELEASE = 10,
  parameter int REST_CYC   = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] bus_i,
  output logic          start_n_o,
  output logic          sel_n_o,
  output logic          rden_n_o,
  output logic          smp_vld_o,
  output logic [DW-1:0] smp_o,
  output logic          tmo_o,
  output logic          ovr_o
);
  localparam int TMO_LIM = CONV_MAX + TMO_MARGIN;
  localparam int TW      = $clog2(TMO_LIM + 1);
  localparam int M1      = (SEL_SETUP > START_LOW) ? SEL_SETUP : START_LOW;
  localparam int M2      = (RD_ACCESS > RD_RELEASE) ? RD_ACCESS : RD_RELEASE;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int PMAX    = (M3 > REST_CYC) ? M3 : REST_CYC;
  localparam int PW      = $clog2(PMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STROBE, S_WAIT, S_READ, S_HOLD, S_REST
  } st_t;

  st_t           st, st_nx;
  logic [PW-1:0] pcnt, pcnt_nx;
  logic [TW-1:0] tcnt;
  logic          rdy_m, rdy_s, rdy_d;
  logic          rdy_rise;
  logic          tmo_hit, cap;

  assign rdy_rise = rdy_s & ~rdy_d;
  assign tmo_hit  = (st == S_WAIT) && !rdy_rise && (tcnt == TW'(TMO_LIM - 1));
  assign cap      = (st == S_READ) && (pcnt == '0);

  always_comb begin
    st_nx   = st;
    pcnt_nx = (pcnt != '0) ? pcnt - 1'b1 : pcnt;
    unique case (st)
      S_IDLE:   if (req_i) begin st_nx = S_SETUP; pcnt_nx = PW'(SEL_SETUP - 1); end
      S_SETUP:  if (pcnt == '0) begin st_nx = S_STROBE; pcnt_nx = PW'(START_LOW - 1); end
      S_STROBE: if (pcnt == '0) st_nx = S_WAIT;
      S_WAIT: begin
        if (rdy_rise) begin st_nx = S_READ; pcnt_nx = PW'(RD_ACCESS - 1); end
        else if (tmo_hit) begin st_nx = S_REST; pcnt_nx = PW'(REST_CYC - 1); end
      end
      S_READ:   if (pcnt == '0) begin st_nx = S_HOLD; pcnt_nx = PW'(RD_RELEASE - 1); end
      S_HOLD:   if (pcnt == '0) begin st_nx = S_REST; pcnt_nx = PW'(REST_CYC - 1); end
      S_REST:   if (pcnt == '0) st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_m <= 1'b1;
      rdy_s <= 1'b1;
      rdy_d <= 1'b1;
    end else begin
      rdy_m <= rdy_i;
      rdy_s <= rdy_m;
      rdy_d <= rdy_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pcnt      <= '0;
      tcnt      <= '0;
      start_n_o <= 1'b1;
      sel_n_o   <= 1'b1;
      rden_n_o  <= 1'b1;
      smp_vld_o <= 1'b0;
      smp_o     <= '0;
      tmo_o     <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      st        <= st_nx;
      pcnt      <= pcnt_nx;
      tcnt      <= (st == S_WAIT) ? tcnt + 1'b1 : '0;
      start_n_o <= (st_nx != S_STROBE);
      sel_n_o   <= (st_nx == S_IDLE) || (st_nx == S_REST);
      rden_n_o  <= (st_nx != S_READ);
      smp_vld_o <= cap;
      tmo_o     <= tmo_hit;
      ovr_o     <= req_i && (st != S_IDLE);
      if (cap) smp_o <= bus_i;
    end
  end
endmodule

// File: rtl/adc_par_reader_chk.sv
module adc_par_reader_chk #(
  parameter int DW        = 16,
  parameter int START_LOW = 6,
  parameter int REST_CYC  = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          rdy_i,
  input logic          start_n_o,
  input logic          sel_n_o,
  input logic          rden_n_o,
  input logic          smp_vld_o,
  input logic [DW-1:0] smp_o,
  input logic          tmo_o,
  input logic          ovr_o
);
  int lowcnt, highcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt  <= 0;
      highcnt <= REST_CYC;
    end else begin
      lowcnt  <= start_n_o ? 0 : lowcnt + 1;
      highcnt <= !sel_n_o ? 0 : (highcnt < REST_CYC ? highcnt + 1 : highcnt);
    end
  end

  p_sel_before_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_n_o) |-> (!sel_n_o && !$past(sel_n_o)));
  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_n_o) |-> (lowcnt == START_LOW));
  p_read_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rden_n_o |-> (rdy_i && start_n_o && !sel_n_o));
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld_o |=> !smp_vld_o);
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_o |-> $stable(smp_o));
  p_rest_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n_o) |-> (highcnt >= REST_CYC));
  p_tmo_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmo_o && smp_vld_o));
  p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> $past(req_i));
endmodule

bind adc_par_reader adc_par_reader_chk #(
  .DW(DW), .START_LOW(START_LOW), .REST_CYC(REST_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .rdy_i(rdy_i),
  .start_n_o(start_n_o), .sel_n_o(sel_n_o), .rden_n_o(rden_n_o),
  .smp_vld_o(smp_vld_o), .smp_o(smp_o), .tmo_o(tmo_o), .ovr_o(ovr_o)
);

// File: tb/tb_adc_par_reader.sv
module tb_adc_par_reader;
  localparam int DW = 16, SETUP = 2, LOW = 3, CMAX = 80, MARG = 8;
  localparam int ACC = 4, REL = 3, REST = 6;
  localparam int TMO = CMAX + MARG;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_i, rdy_i;
  logic [DW-1:0] bus_i, smp_o;
  logic start_n_o, sel_n_o, rden_n_o, smp_vld_o, tmo_o, ovr_o;

  adc_par_reader #(.DW(DW), .SEL_SETUP(SETUP), .START_LOW(LOW), .CONV_MAX(CMAX),
    .TMO_MARGIN(MARG), .RD_ACCESS(ACC), .RD_RELEASE(REL), .REST_CYC(REST)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .rdy_i(rdy_i), .bus_i(bus_i),
    .start_n_o(start_n_o), .sel_n_o(sel_n_o), .rden_n_o(rden_n_o),
    .smp_vld_o(smp_vld_o), .smp_o(smp_o), .tmo_o(tmo_o), .ovr_o(ovr_o));

  int nchk = 0, nfail = 0, cyc = 0;
  int nvalid = 0, ntmo = 0, nstart = 0, nrd = 0;
  int sel_fall = 0, sel_rise = -1000, st_fall = 0, st_rise = 0, last_rise = -1000;
  int dev_left = 0, rd_low = 0, seed0;
  bit dev_on = 0, stuck = 0, kick = 0, finished = 0;
  bit p_sel = 1, p_st = 1, p_rd = 1;
  logic [DW-1:0] next_word = '0, cur_word = '0, exp_word = '0;
  int next_len = 10;

  assign bus_i = (!sel_n_o && !rden_n_o && rd_low >= 2) ? cur_word : ~cur_word;
  always @(posedge clk) rd_low <= rden_n_o ? 0 : rd_low + 1;

  function automatic int exp_lat();
    return 3 + ACC;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_sel && !sel_n_o) begin
        chk(cyc - sel_rise >= REST, "R6", "select rest", cyc - sel_rise, REST);
        sel_fall = cyc;
      end
      if (!p_sel && sel_n_o) sel_rise = cyc;
      if (p_st && !start_n_o) begin
        chk(cyc - sel_fall == SETUP, "R2", "setup cycles", cyc - sel_fall, SETUP);
        chk(cyc - last_rise >= REST, "R6", "start after ready", cyc - last_rise, REST);
        st_fall = cyc; nstart++;
      end
      if (!p_st && start_n_o) begin
        chk(cyc - st_fall == LOW, "R3", "strobe width", cyc - st_fall, LOW);
        st_rise = cyc;
      end
      if (p_rd && !rden_n_o) begin
        nrd++;
        chk(rdy_i && (cyc - last_rise == 3), "R4", "read start", cyc - last_rise, 3);
      end
      if (smp_vld_o) begin
        nvalid++;
        chk(smp_o == exp_word, "R5", "sample word", smp_o, exp_word);
        chk(cyc - last_rise == exp_lat(), "R5", "latency", cyc - last_rise, exp_lat());
      end
      if (tmo_o) begin
        ntmo++;
        chk(cyc - st_rise == TMO, "R7", "timeout cycles", cyc - st_rise, TMO);
      end
      if (kick) begin
        rdy_i <= 1'b1; dev_on = 0; kick = 0;
      end else if (p_st && !start_n_o && !sel_n_o && !dev_on) begin
        rdy_i <= 1'b0; dev_on = 1; dev_left = next_len;
      end else if (dev_on && !stuck) begin
        if (dev_left == 0) begin
          rdy_i <= 1'b1; dev_on = 0; last_rise = cyc;
          cur_word = next_word; exp_word = next_word;
        end else dev_left--;
      end
    end
    p_sel = sel_n_o; p_st = start_n_o; p_rd = rden_n_o;
  end

  task automatic pulse_req();
    @(negedge clk); req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
  endtask

  task automatic wait_done();
    int v0, t0;
    v0 = nvalid; t0 = ntmo;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (nvalid != v0 || ntmo != t0) break;
    end
    repeat (REL + REST + 4) @(negedge clk);
  endtask

  task automatic run_one(input logic [DW-1:0] w, input int len, input string rq);
    int v0;
    v0 = nvalid;
    next_word = w; next_len = len;
    pulse_req();
    wait_done();
    chk(nvalid == v0 + 1, rq, "one valid", nvalid - v0, 1);
    chk(smp_o == w, rq, "held word", smp_o, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    seed0 = $urandom(32'd4711);
    rst_n = 1'b0; req_i = 1'b0; rdy_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(sel_n_o && start_n_o && rden_n_o && !smp_vld_o && !tmo_o && !ovr_o,
        "R1", "reset outputs", {sel_n_o, start_n_o, rden_n_o, smp_vld_o, tmo_o, ovr_o}, 6'b111000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_one(16'h8000, 20, "R9");
    chk(smp_o[15] == 1'b1, "R9", "sign bit", smp_o[15], 1);
    run_one(16'h7FFF, 1, "R9");
    run_one(16'h0000, CMAX - 2, "R5");
    run_one(16'hFFFF, 5, "R9");

    // R8: request during conversion
    next_word = 16'h1234; next_len = 40;
    pulse_req();
    while (rdy_i) @(negedge clk);
    req_i = 1'b1; @(negedge clk); req_i = 1'b0;
    chk(ovr_o == 1'b1, "R8", "overrun in conversion", ovr_o, 1);
    for (int i = 0; i < 3000 && !smp_vld_o; i++) @(negedge clk);
    // R8: request during rest interval
    repeat (2) @(negedge clk);
    req_i = 1'b1; @(negedge clk); req_i = 1'b0;
    chk(ovr_o == 1'b1, "R8", "overrun in rest", ovr_o, 1);
    repeat (REL + REST + 6) @(negedge clk);
    chk(nstart == nvalid + ntmo, "R8", "no extra start", nstart, nvalid + ntmo);
    chk(smp_o == 16'h1234, "R5", "word after overrun", smp_o, 16'h1234);

    // R7: stuck converter
    begin
      int v0, r0;
      v0 = nvalid; r0 = nrd;
      stuck = 1;
      pulse_req();
      wait_done();
      chk(ntmo == 1, "R7", "timeout count", ntmo, 1);
      chk(nvalid == v0 && nrd == r0, "R7", "no read on timeout", nrd - r0, 0);
      chk(smp_o == 16'h1234, "R7", "word kept", smp_o, 16'h1234);
      stuck = 0;
      @(posedge clk); kick = 1;
      repeat (10) @(negedge clk);
      chk(nrd == r0 && rden_n_o, "R4", "late ready ignored", nrd - r0, 0);
    end
    run_one(16'h5A5A, 12, "R7");

    for (int k = 0; k < 30; k++) begin
      logic [DW-1:0] w;
      int len;
      w = DW'($urandom);
      len = 1 + int'($urandom % (CMAX - 2));
      if ((k % 4) == 3) begin
        next_word = w; next_len = len;
        pulse_req();
        while (rdy_i) @(negedge clk);
        req_i = 1'b1; @(negedge clk); req_i = 1'b0;
        chk(ovr_o == 1'b1, "R8", "random overrun", ovr_o, 1);
        wait_done();
        chk(smp_o == w, "R5", "random word", smp_o, w);
      end else begin
        run_one(w, len, "R5");
      end
      repeat ($urandom % 8) @(negedge clk);
    end
    chk(nstart == nvalid + ntmo, "R3", "one start per request", nstart, nvalid + ntmo);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule